// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block gathers interrupt events from several functional sections of a chip into one interrupt line for a host processor. Every section owns a pending register and an enable register of the same width. A one-clock pulse on an event input latches the matching pending bit; the host clears a pending bit by writing a one to it. An enable bit decides whether its pending bit may take part in the interrupt.

A global summary word holds one bit per section, set while that section has at least one pending bit whose enable is also set. The summary needs no acknowledge: it is a reduction of the section registers and falls as soon as the pending bits are cleared or their enables are dropped. The OR of all summary bits, registered, drives a pull-low enable that models an active-low open-drain interrupt pin.

The host reaches all registers through a 32-bit word-addressed port with separate read and write strobes and a registered read result.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is high, all pending and enable bits clear; on the cycle after reset, `irq_pull_low` is 0 and `host_rdata` is 0.
- R2: An event pulse on bit b of section s (input bit s*SECT_W+b of `evt_in`) sets pending bit b of section s at the clock edge that samples it; the host reads pending register s at word address 2*s.
- R3: A write to word address 2*s clears each pending bit of section s whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: When an event and a clearing write hit the same pending bit at the same edge, the bit is set after that edge.
- R5: A write to word address 2*s+1 loads the low SECT_W data bits into the enable register of section s; reading that address returns them with the upper bits zero, and enables read zero after reset.
- R6: Reading word address 2*NUM_SECT returns the summary word: bit s is 1 exactly when section s has a bit that is both pending and enabled; all higher bits are 0.
- R7: `irq_pull_low` is 1 one clock after any summary bit is 1 and 0 one clock after all summary bits are 0.
- R8: Clearing a section's enable bits drops its summary bit and releases `irq_pull_low` without any acknowledge; the pending bits are kept.
- R9: Writes to word address 2*NUM_SECT or to any higher address change no pending or enable bit.
- R10: `host_rdata` is updated only at an edge where `host_rd_en` is 1, with the register value from before that edge, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_SECT*SECT_W | One-clock event pulses, section s in bits s*SECT_W and up |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| irq_pull_low | output | 1 | Drive-low enable for the open-drain interrupt pin |

## Verification
The event input and a host write-one-to-clear can land on the same pending bit in one cycle. The bench provokes this by first latching a bit, then driving its event pulse and a clearing write in the same cycle, and judges it by reading the register back, which must still show the bit set. A random phase keeps events, clearing writes, enable writes and reads overlapping freely, with a behavioural model of queue-free integer state compared against the read data and interrupt output on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int HOST_DW = 32;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_EN,
    SEL_GLOB
  } sel_e;

  typedef struct packed {
    sel_e       kind;
    logic [7:0] sect;
  } reg_dec_t;

  // Word map: pending of section s at 2*s, enable at 2*s+1, summary after them.
  function automatic reg_dec_t decode_addr(logic [7:0] word, int nsect);
    reg_dec_t d;
    d.kind = SEL_NONE;
    d.sect = '0;
    for (int s = 0; s < nsect; s++) begin
      if (word == 8'(2 * s)) begin
        d.kind = SEL_PEND;
        d.sect = 8'(s);
      end
      if (word == 8'(2 * s + 1)) begin
        d.kind = SEL_EN;
        d.sect = 8'(s);
      end
    end
    if (word == 8'(2 * nsect)) d.kind = SEL_GLOB;
    return d;
  endfunction

endpackage

// File: rtl/irq_section.sv
module irq_section #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] en_q,
  output logic         active
);

  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // event has priority over a clear of the same bit
      pend_q <= (pend_q & ~clr_mask) | evt;
      if (en_we) en_q <= wdata;
    end
  end

  assign active = |(pend_q & en_q);

endmodule

// File: rtl/irq_regread.sv
module irq_regread
  import irq_agg_pkg::*;
#(
  parameter int NS = 4,
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [NS*W-1:0]    pend_flat,
  input  logic [NS*W-1:0]    en_flat,
  input  logic [NS-1:0]      sum,
  output logic [HOST_DW-1:0] rdata
);

  reg_dec_t           dec;
  logic [HOST_DW-1:0] rd_word;

  always_comb begin
    dec     = decode_addr(8'(addr), NS);
    rd_word = '0;
    unique case (dec.kind)
      SEL_PEND: rd_word[W-1:0]  = pend_flat[int'(dec.sect)*W +: W];
      SEL_EN:   rd_word[W-1:0]  = en_flat[int'(dec.sect)*W +: W];
      SEL_GLOB: rd_word[NS-1:0] = sum;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int SECT_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SECT*SECT_W-1:0] evt_in,
  input  logic                       host_wr_en,
  input  logic                       host_rd_en,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [31:0]                host_wdata,
  output logic [31:0]                host_rdata,
  output logic                       irq_pull_low
);

  localparam int FLAT_W = NUM_SECT * SECT_W;

  reg_dec_t            wdec;
  logic [FLAT_W-1:0]   pend_flat;
  logic [FLAT_W-1:0]   en_flat;
  logic [NUM_SECT-1:0] sum;
  logic [NUM_SECT-1:0] clr_we;
  logic [NUM_SECT-1:0] en_we;

  assign wdec = decode_addr(8'(host_addr), NUM_SECT);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign clr_we[s] = host_wr_en && (wdec.kind == SEL_PEND) && (wdec.sect == 8'(s));
    assign en_we[s]  = host_wr_en && (wdec.kind == SEL_EN)   && (wdec.sect == 8'(s));

    irq_section #(.W(SECT_W)) u_sect (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_in[s*SECT_W +: SECT_W]),
      .clr_we (clr_we[s]),
      .en_we  (en_we[s]),
      .wdata  (host_wdata[SECT_W-1:0]),
      .pend_q (pend_flat[s*SECT_W +: SECT_W]),
      .en_q   (en_flat[s*SECT_W +: SECT_W]),
      .active (sum[s])
    );
  end

  irq_regread #(.NS(NUM_SECT), .W(SECT_W), .AW(ADDR_W)) u_read (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (host_rd_en),
    .addr      (host_addr),
    .pend_flat (pend_flat),
    .en_flat   (en_flat),
    .sum       (sum),
    .rdata     (host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_pull_low <= 1'b0;
    else     irq_pull_low <= |sum;
  end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NS = 4,
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NS*W-1:0] evt_in,
  input logic          host_wr_en,
  input logic          host_rd_en,
  input logic [AW-1:0] host_addr,
  input logic [31:0]   host_rdata,
  input logic          irq_pull_low,
  input logic [NS*W-1:0] pend_flat,
  input logic [NS*W-1:0] en_flat,
  input logic [NS-1:0] sum
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq_pull_low && host_rdata == '0 && pend_flat == '0 && en_flat == '0));

  a_r4_event_sets_bit: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((pend_flat & $past(evt_in)) == $past(evt_in)));

  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_flat & ~$past(pend_flat) & ~$past(evt_in)) == '0));

  a_r7_irq_assert: assert property (@(posedge clk) disable iff (rst)
    (|sum) |=> irq_pull_low);

  a_r7_irq_release: assert property (@(posedge clk) disable iff (rst)
    !(|sum) |=> !irq_pull_low);

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd_en |=> $stable(host_rdata));

  a_r9_high_write_inert: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_addr >= AW'(2 * NS))
      |=> ($stable(en_flat) && ((~pend_flat & $past(pend_flat)) == '0)));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NS(NUM_SECT), .W(SECT_W), .AW(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_in       (evt_in),
  .host_wr_en   (host_wr_en),
  .host_rd_en   (host_rd_en),
  .host_addr    (host_addr),
  .host_rdata   (host_rdata),
  .irq_pull_low (irq_pull_low),
  .pend_flat    (pend_flat),
  .en_flat      (en_flat),
  .sum          (sum)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

  localparam int  NS       = 4;
  localparam int  W        = 16;
  localparam int  AW       = 4;
  localparam time CLK_PER  = 10ns;
  localparam int  GLOB     = 2 * NS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS*W-1:0] evt_in = '0;
  logic            host_wr_en = 1'b0;
  logic            host_rd_en = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [31:0]     host_wdata = '0;
  logic [31:0]     host_rdata;
  logic            irq_pull_low;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  string cur_tag  = "R1";

  // behavioural reference state
  logic [W-1:0] pend_m [NS];
  logic [W-1:0] en_m   [NS];
  logic [31:0]  rdata_m = '0;
  logic         irq_m   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  irq_aggregator #(.NUM_SECT(NS), .SECT_W(W), .ADDR_W(AW)) dut (
    .clk          (clk),
    .rst          (rst),
    .evt_in       (evt_in),
    .host_wr_en   (host_wr_en),
    .host_rd_en   (host_rd_en),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .irq_pull_low (irq_pull_low)
  );

  function automatic logic [31:0] model_read(int a);
    logic [31:0] v = '0;
    for (int s = 0; s < NS; s++) begin
      if (a == 2 * s)     v = 32'(pend_m[s]);
      if (a == 2 * s + 1) v = 32'(en_m[s]);
      if (a == GLOB && (pend_m[s] & en_m[s]) != 0) v[s] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        pend_m[s] = '0;
        en_m[s]   = '0;
      end
      rdata_m = '0;
      irq_m   = 1'b0;
    end else begin
      logic any_act;
      any_act = 1'b0;
      for (int s = 0; s < NS; s++) if ((pend_m[s] & en_m[s]) != 0) any_act = 1'b1;
      if (host_rd_en) rdata_m = model_read(int'(host_addr));
      irq_m = any_act;
      for (int s = 0; s < NS; s++) begin
        if (host_wr_en && int'(host_addr) == 2 * s) pend_m[s] = pend_m[s] & ~host_wdata[W-1:0];
        pend_m[s] = pend_m[s] | evt_in[s*W +: W];
        if (host_wr_en && int'(host_addr) == 2 * s + 1) en_m[s] = host_wdata[W-1:0];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({cur_tag, " rdata vs model"}, host_rdata, rdata_m);
      chk({cur_tag, " irq vs model"}, 32'(irq_pull_low), 32'(irq_m));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = AW'(a);
    @(negedge clk);
    host_rd_en = 1'b0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic pulse(int s, logic [W-1:0] bits);
    @(negedge clk);
    evt_in = '0; evt_in[s*W +: W] = bits;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R5: reset state
    cur_tag = "R1";
    chk("R1 irq after reset", 32'(irq_pull_low), 32'd0);
    for (int a = 0; a <= GLOB; a++) rd(a, 32'd0, "R1 register zero after reset");
    rd(1, 32'd0, "R5 enable zero after reset");

    // R5: enable write masks to section width
    cur_tag = "R5";
    wr(3, 32'hFFFF_1234);
    rd(3, 32'h0000_1234, "R5 enable readback");
    wr(3, 32'd0);

    // R2: event latches, no interrupt while disabled
    cur_tag = "R2";
    pulse(2, 16'h0008);
    rd(4, 32'h8, "R2 pending latched");
    chk("R7 no irq while disabled", 32'(irq_pull_low), 32'd0);
    rd(GLOB, 32'd0, "R6 summary zero while disabled");

    // R6 / R7: enabling raises summary and interrupt
    cur_tag = "R7";
    wr(5, 32'h8);
    @(negedge clk);
    chk("R7 irq asserted", 32'(irq_pull_low), 32'd1);
    rd(GLOB, 32'h4, "R6 summary bit of section 2");

    // R8: disabling releases without acknowledge
    cur_tag = "R8";
    wr(5, 32'd0);
    @(negedge clk);
    chk("R8 irq released on disable", 32'(irq_pull_low), 32'd0);
    rd(GLOB, 32'd0, "R8 summary clear on disable");
    rd(4, 32'h8, "R8 pending kept");

    // R3: write-one-to-clear is selective
    cur_tag = "R3";
    pulse(2, 16'h0030);
    wr(4, 32'd0);
    rd(4, 32'h38, "R3 zero write keeps bits");
    wr(4, 32'h8);
    rd(4, 32'h30, "R3 one clears only that bit");

    // R4: event and clear collide on one bit
    cur_tag = "R4";
    pulse(0, 16'h0020);
    @(negedge clk);
    evt_in = '0; evt_in[5] = 1'b1;
    host_wr_en = 1'b1; host_addr = AW'(0); host_wdata = 32'h20;
    @(negedge clk);
    evt_in = '0; host_wr_en = 1'b0;
    rd(0, 32'h20, "R4 event wins over clear");

    // R9: writes at and above the summary address are inert
    cur_tag = "R9";
    for (int a = GLOB; a < (1 << AW); a++) wr(a, 32'hFFFF_FFFF);
    rd(0, 32'h20, "R9 section 0 pending unchanged");
    rd(4, 32'h30, "R9 section 2 pending unchanged");
    rd(5, 32'h0, "R9 section 2 enable unchanged");
    rd(GLOB, 32'h0, "R9 summary unchanged");

    // R6 / R7: two sections active, clear one at a time
    cur_tag = "R7";
    wr(1, 32'h20);
    wr(7, 32'h1);
    pulse(3, 16'h0001);
    @(negedge clk);
    chk("R7 irq with two sections", 32'(irq_pull_low), 32'd1);
    rd(GLOB, 32'h9, "R6 summary sections 0 and 3");
    wr(0, 32'h20);
    @(negedge clk);
    chk("R7 irq held by section 3", 32'(irq_pull_low), 32'd1);
    wr(6, 32'h1);
    @(negedge clk);
    chk("R7 irq released after last clear", 32'(irq_pull_low), 32'd0);

    // R10: read data holds without a read strobe
    cur_tag = "R10";
    rd(4, 32'h30, "R10 read before hold");
    pulse(2, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", host_rdata, 32'h30);

    // random overlap of all operations, judged by the model
    cur_tag = "R2 R3 R4 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      evt_in     = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      host_wr_en = ($urandom % 3) == 0;
      host_rd_en = ($urandom % 2) == 0;
      host_addr  = AW'($urandom);
      host_wdata = $urandom;
    end
    @(negedge clk);
    evt_in = '0; host_wr_en = 1'b0; host_rd_en = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule